// File: doc/BRIEF.md
# Transfer Count and DMA Length Unit

This block holds the 16-bit transfer count of a bus controller and runs the down-counting length engine behind its DMA transfers. Software writes the low and middle count bytes into shadow registers. Any command byte whose top bit is set copies the shadow pair into the live count. A transfer command issued in DMA mode works out how many bytes will actually move. That figure is the programmed count, where zero stands for 65536, clamped to the bytes the bus still has to move. While the controller is still gathering a command, the clamp is 32 bytes instead. The block then counts accepted byte beats down to zero.

When the last beat is accepted, the unit sets its terminal-count flag, clears the live count, and raises an interrupt with the bus-service cause code. Bus phases and memory-side signalling belong to neighbouring logic. The byte beats of the external DMA port arrive here as a plain valid/ready pair.

Top module: `xfer_cnt_unit`

## Requirements
- R1: After reset, the shadow and live counts, the remaining length, busy, terminal count, interrupt, cause code and done are all zero.
- R2: A host write with `host_sel`=0 loads the low byte of the shadow count and `host_sel`=1 loads the middle byte. Host writes leave the live count unchanged.
- R3: A host write to either count byte clears the terminal-count flag on the next edge.
- R4: A command byte with bit 7 set copies the shadow count into the live count. A command byte with bit 7 clear leaves the live count unchanged and starts no transfer, even when its low seven bits are the transfer opcode 0x10.
- R5: The transfer command is 0x90 (bit 7 set, low seven bits 0x10). When the count it uses is zero, the count is taken as 65536 bytes.
- R6: With `collecting`=0, the remaining length after a transfer command equals the smaller of the count and `data_left`.
- R7: With `collecting`=1, the remaining length after a transfer command equals the smaller of the count and 32, whatever `data_left` is.
- R8: Starting a transfer clears terminal count. `busy` and `beat_ready` are high exactly while the remaining length is non-zero. Each cycle with `beat_valid` and `beat_ready` both high lowers the length by one. `beat_valid` while idle changes nothing.
- R9: Accepting the last beat sets terminal count, zeroes the live count, raises `irq` with cause code 0x10, and pulses `done` for one cycle.
- R10: A transfer command whose effective length is zero completes at once, with the same outcome as R9 and no beats accepted.
- R11: `irq_ack` clears `irq` and the cause code on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for a count byte |
| host_sel | input | 1 | 0 selects the low byte, 1 the middle byte |
| host_wdata | input | 8 | Count byte written by the host |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte; bit 7 selects DMA mode |
| collecting | input | 1 | Controller is gathering a command |
| data_left | input | 17 | Bytes still to move on the bus |
| beat_valid | input | 1 | DMA port offers a byte |
| beat_ready | output | 1 | Unit accepts a byte |
| irq_ack | input | 1 | Interrupt acknowledge |
| live_count | output | 16 | Live transfer count |
| remaining | output | 17 | Bytes left in the running transfer |
| busy | output | 1 | Transfer in progress |
| tc_flag | output | 1 | Terminal-count status |
| irq | output | 1 | Interrupt request |
| irq_code | output | 8 | Interrupt cause code |
| done | output | 1 | One-cycle completion pulse |

## Verification
The length computation is swept over counts of 0, 1, 2, 31, 32, 33, 0x0123 and 0xFFFF. Each count is paired with remaining-data values of 0, 1, 7, 300 and 65536, with and without command collection. This separates the zero-means-65536 rule from a plain minimum, and the 32-byte clamp from the data clamp at both edges of 32. Short transfers are run beat by beat, so the number of accepted beats must match the computed length. One full 65536-byte run exercises the widest case. Other cases cover commands without the DMA bit, idle beats, a zero-length start, and host writes after completion. These show which of reload, start, flag clearing and interrupt acknowledge each input controls.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;
  localparam int          DMA_BIT     = 7;
  localparam logic [6:0]  OP_XFER     = 7'h10;
  localparam logic [7:0]  CAUSE_SVC   = 8'h10;
endpackage

// File: rtl/xfer_cnt_regs.sv
module xfer_cnt_regs #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              reload,
  input  logic              clear,
  output logic [CNT_W-1:0]  shadow_cnt,
  output logic [CNT_W-1:0]  live_cnt
);
  localparam int LANES = CNT_W / BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        shadow_cnt[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr && (int'(sel) == g))
        shadow_cnt[g*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       live_cnt <= '0;
    else if (clear)   live_cnt <= '0;
    else if (reload)  live_cnt <= shadow_cnt;
  end
endmodule

// File: rtl/xfer_len_calc.sv
module xfer_len_calc #(
  parameter int CNT_W   = 16,
  parameter int LEN_W   = CNT_W + 1,
  parameter int CMD_CAP = 32
) (
  input  logic [CNT_W-1:0] count,
  input  logic             collecting,
  input  logic [LEN_W-1:0] data_left,
  output logic [LEN_W-1:0] eff_len
);
  function automatic logic [LEN_W-1:0] span(input logic [CNT_W-1:0] c);
    return (c == '0) ? (LEN_W'(1) << CNT_W) : LEN_W'(c);
  endfunction

  function automatic logic [LEN_W-1:0] lesser(input logic [LEN_W-1:0] a,
                                              input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [LEN_W-1:0] limit;
  assign limit   = collecting ? LEN_W'(CMD_CAP) : data_left;
  assign eff_len = lesser(span(count), limit);
endmodule

// File: rtl/xfer_dma_engine.sv
module xfer_dma_engine
  import xfer_cnt_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] eff_len,
  input  logic             beat_valid,
  input  logic             tc_clr,
  input  logic             irq_ack,
  output logic [LEN_W-1:0] remaining,
  output logic             busy,
  output logic             accept,
  output logic             finish_ev,
  output logic             tc_flag,
  output logic             irq,
  output logic [7:0]       irq_code,
  output logic             done
);
  assign busy      = (remaining != '0);
  assign accept    = busy && beat_valid;
  assign finish_ev = start ? (eff_len == '0)
                           : (accept && remaining == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      tc_flag   <= 1'b0;
      irq       <= 1'b0;
      irq_code  <= '0;
      done      <= 1'b0;
    end else begin
      done <= finish_ev;
      if (start)       remaining <= eff_len;
      else if (accept) remaining <= remaining - LEN_W'(1);

      if (finish_ev)                tc_flag <= 1'b1;
      else if (start || tc_clr)     tc_flag <= 1'b0;

      if (finish_ev) begin
        irq      <= 1'b1;
        irq_code <= CAUSE_SVC;
      end else if (irq_ack) begin
        irq      <= 1'b0;
        irq_code <= '0;
      end
    end
  end
endmodule

// File: rtl/xfer_cnt_unit.sv
module xfer_cnt_unit
  import xfer_cnt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CMD_CAP = 32,
  parameter int LEN_W   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_sel,
  input  logic [7:0]       host_wdata,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             collecting,
  input  logic [LEN_W-1:0] data_left,
  input  logic             beat_valid,
  output logic             beat_ready,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] live_count,
  output logic [LEN_W-1:0] remaining,
  output logic             busy,
  output logic             tc_flag,
  output logic             irq,
  output logic [7:0]       irq_code,
  output logic             done
);
  logic             dma_cmd, start, accept, finish_ev;
  logic [CNT_W-1:0] shadow_cnt, cnt_src;
  logic [LEN_W-1:0] eff_len;

  assign dma_cmd = cmd_valid && cmd_byte[DMA_BIT];
  assign start   = dma_cmd && (cmd_byte[6:0] == OP_XFER);
  assign cnt_src = dma_cmd ? shadow_cnt : live_count;

  xfer_cnt_regs #(.CNT_W(CNT_W), .BYTE_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .sel(host_sel),
    .wdata(host_wdata), .reload(dma_cmd), .clear(finish_ev),
    .shadow_cnt(shadow_cnt), .live_cnt(live_count)
  );

  xfer_len_calc #(.CNT_W(CNT_W), .LEN_W(LEN_W), .CMD_CAP(CMD_CAP)) u_len (
    .count(cnt_src), .collecting(collecting), .data_left(data_left),
    .eff_len(eff_len)
  );

  xfer_dma_engine #(.LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .eff_len(eff_len),
    .beat_valid(beat_valid), .tc_clr(host_wr), .irq_ack(irq_ack),
    .remaining(remaining), .busy(busy), .accept(accept),
    .finish_ev(finish_ev), .tc_flag(tc_flag), .irq(irq),
    .irq_code(irq_code), .done(done)
  );

  assign beat_ready = busy;
endmodule

// File: rtl/xfer_cnt_unit_chk.sv
module xfer_cnt_unit_chk #(
  parameter int CNT_W = 16,
  parameter int LEN_W = CNT_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             cmd_valid,
  input logic [7:0]       cmd_byte,
  input logic             beat_valid,
  input logic             beat_ready,
  input logic             irq_ack,
  input logic [CNT_W-1:0] live_count,
  input logic [LEN_W-1:0] remaining,
  input logic             tc_flag,
  input logic             irq,
  input logic [7:0]       irq_code,
  input logic             done
);
  // R3
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (!tc_flag || done));

  // R4
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_byte[7]) |=> ($stable(live_count) || done));

  // R8
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !cmd_valid) |=> (remaining == $past(remaining) - 1'b1));

  // R8
  idle_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_ready && !cmd_valid) |=> (remaining == '0));

  // R9
  finish_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tc_flag && irq && irq_code == 8'h10 && live_count == '0));

  // R11
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!irq || done));
endmodule

bind xfer_cnt_unit xfer_cnt_unit_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .cmd_valid(cmd_valid),
  .cmd_byte(cmd_byte), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .irq_ack(irq_ack), .live_count(live_count), .remaining(remaining),
  .tc_flag(tc_flag), .irq(irq), .irq_code(irq_code), .done(done)
);

// File: tb/xfer_cnt_unit_test.sv
module xfer_cnt_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_sel = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        collecting = 1'b0;
  logic [16:0] data_left = '0;
  logic        beat_valid = 1'b0, irq_ack = 1'b0;
  logic        beat_ready, busy, tc_flag, irq, done;
  logic [15:0] live_count;
  logic [16:0] remaining;
  logic [7:0]  irq_code;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  xfer_cnt_unit uut (.*);

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_count(input logic [15:0] v);
    host_wr = 1'b1; host_sel = 1'b0; host_wdata = v[7:0]; step();
    host_sel = 1'b1; host_wdata = v[15:8]; step();
    host_wr = 1'b0;
  endtask

  task automatic issue(input logic [7:0] c);
    cmd_valid = 1'b1; cmd_byte = c; step();
    cmd_valid = 1'b0; cmd_byte = '0;
  endtask

  function automatic longint exp_len(input longint c, input bit coll, input longint left);
    longint l = (c == 0) ? 65536 : c;
    longint cap = coll ? 32 : left;
    return (l < cap) ? l : cap;
  endfunction

  task automatic run_beats(input longint e, input string req);
    longint n = 0;
    beat_valid = 1'b1;
    while (busy && n < 70000) begin
      step(); n++;
      if (n == 1 && e > 1) check({req, " step"}, remaining, e - 1);
    end
    check({req, " beats"}, n, e);
    check("R9 done", done, 1);
    check("R9 tc", tc_flag, 1);
    check("R9 live", live_count, 0);
    check("R9 irq", irq, 1);
    check("R9 code", irq_code, 8'h10);
    beat_valid = 1'b0;
    step();
    check("R9 pulse", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint cnts[8] = '{0, 1, 2, 31, 32, 33, 'h0123, 'hFFFF};
    longint lefts[5] = '{0, 1, 7, 300, 65536};
    longint e;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1
    check("R1 live", live_count, 0); check("R1 rem", remaining, 0);
    check("R1 busy", busy, 0); check("R1 tc", tc_flag, 0);
    check("R1 irq", irq, 0); check("R1 code", irq_code, 0);
    check("R1 done", done, 0);

    // R8 idle beats ignored
    beat_valid = 1'b1; step(); step(); beat_valid = 1'b0;
    check("R8 idle rem", remaining, 0); check("R8 idle ready", beat_ready, 0);

    // R2 / R4
    wr_count(16'h0042);
    check("R2 live untouched", live_count, 0);
    issue(8'h10);
    check("R4 nodma live", live_count, 0); check("R4 nodma busy", busy, 0);
    issue(8'h80);
    check("R4 reload", live_count, 16'h0042); check("R4 reload idle", busy, 0);
    wr_count(16'h1234);
    check("R2 shadow not live", live_count, 16'h0042);
    issue(8'h81);
    check("R2 byte lanes", live_count, 16'h1234);

    // sweep: R5 R6 R7
    for (int ci = 0; ci < 8; ci++)
      for (int li = 0; li < 5; li++)
        for (int k = 0; k < 2; k++) begin
          wr_count(cnts[ci][15:0]);
          collecting = k[0]; data_left = lefts[li][16:0];
          e = exp_len(cnts[ci], k[0], lefts[li]);
          issue(8'h90);
          if (k == 1) check("R7 len", remaining, e);
          else if (cnts[ci] == 0) check("R5 len", remaining, e);
          else check("R6 len", remaining, e);
          if (e == 0) begin
            // R10
            check("R10 done", done, 1); check("R10 tc", tc_flag, 1);
            check("R10 irq", irq, 1); check("R10 busy", busy, 0);
          end else begin
            check("R8 busy", busy, 1); check("R8 tc clear", tc_flag, 0);
            if (e <= 40) run_beats(e, "R8");
          end
          irq_ack = 1'b1; step(); irq_ack = 1'b0;
          check("R11 irq", irq, 0); check("R11 code", irq_code, 0);
        end

    // full 65536 transfer
    wr_count(16'h0000); collecting = 1'b0; data_left = 17'h10000;
    issue(8'h90);
    check("R5 full", remaining, 65536);
    run_beats(65536, "R5");

    // R3: host write clears tc
    check("R3 pre", tc_flag, 1);
    host_wr = 1'b1; host_sel = 1'b1; host_wdata = 8'h00; step(); host_wr = 1'b0;
    check("R3 mid write", tc_flag, 0);
    wr_count(16'h0003); issue(8'h90);
    run_beats(3, "R8");
    host_wr = 1'b1; host_sel = 1'b0; host_wdata = 8'h07; step(); host_wr = 1'b0;
    check("R3 low write", tc_flag, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule